// File: doc/BRIEF.md
# Four-Point Complex DFT Butterfly

This block takes four complex samples in natural order and produces their four-point discrete Fourier transform, also in natural order, in a single arithmetic stage. Every coefficient of the four-point transform is one of +1, -1, +j or -j. The datapath therefore has no multipliers. Each output is a signed sum of the inputs, and in that sum the real and imaginary parts of two of the inputs may trade places.

Samples travel as sign-magnitude words. The top bit is the sign. With the default width of 8, bits 6:4 hold the integer part and bits 3:0 the fraction, so the range is ±7.9375. Inside the block the words are converted to two's complement and widened by two bits, so that the sums are exact. The results are then folded back to sign-magnitude with saturation and registered. A strobe marks each input set, and a matching strobe marks the result one clock later. A build-time option chooses between two arithmetic arrangements:

- a direct four-term sum for every output, or
- a shared arrangement that first forms the sum and difference of each input pair and then reuses them.

Both arrangements give the same results.

Top module: `fft4_radix4`

## Requirements
- R1: Each real and each imaginary value is a DW-bit sign-magnitude word. Bit DW-1 is the sign (1 = negative) and the low DW-1 bits are the magnitude; with DW=8, bits 6:4 are the integer part and bits 3:0 the fraction, in units of 1/16. Lane k of a bus sits at bits [k*DW +: DW], for k = 0 to 3.
- R2: Output lane 0 equals x0 + x1 + x2 + x3.
- R3: Output lane 1 equals x0 - j·x1 - x2 + j·x3.
- R4: Output lane 2 equals x0 - x1 + x2 - x3.
- R5: Output lane 3 equals x0 + j·x1 - x2 - j·x3.
- R6: A factor of ±j is applied by exchanging real and imaginary parts and negating one of them. For example, an input x1 = +0.5j alone gives lane 1 = +0.5 and lane 3 = -0.5.
- R7: A result whose magnitude exceeds the largest code (0x7F, 7.9375 at DW=8) saturates to that magnitude and keeps its sign.
- R8: A zero result is always encoded with the sign bit cleared. An input of negative zero (sign set, magnitude 0) counts as zero.
- R9: out_vld is high in exactly the cycle after in_vld was sampled high, and the results of that input set appear in the same cycle.
- R10: When in_vld is sampled low, out_re and out_im keep their previous values whatever the inputs are.
- R11: After reset, out_vld is low and every output word is zero.
- R12: Real inputs 0.75, 0.5, 0.25, 0.0625 (0x0C, 0x08, 0x04, 0x01) give the following results:

  | Lane | Real | Imaginary | Value |
  |---|---|---|---|
  | 0 | 0x19 | 0x00 | 1.5625 |
  | 1 | 0x08 | 0x87 | 0.5 - 0.4375j |
  | 2 | 0x07 | 0x00 | 0.4375 |
  | 3 | 0x08 | 0x07 | 0.5 + 0.4375j |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input set valid strobe |
| in_re | input | 4*DW | Real parts of x0..x3, lane k at [k*DW +: DW] |
| in_im | input | 4*DW | Imaginary parts of x0..x3 |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_re | output | 4*DW | Real parts of X0..X3 |
| out_im | output | 4*DW | Imaginary parts of X0..X3 |

## Verification
The bench builds the block twice at DW=8: once with the shared pair-sum arrangement and once with the direct four-term arrangement. Both instances are checked against the same model, so a fault in either arrangement's sign pattern or real/imaginary exchange shows up as a lane mismatch. Random codes that include negative zero are mixed with directed sets at full positive and full negative scale, where the intermediate sums reach ±508. These sets drive both saturation directions and exact cancellation to zero.

// File: rtl/fft4_pkg.sv
package fft4_pkg;
   localparam int LANES = 4;

   typedef enum logic {
      ARCH_DIRECT = 1'b0,
      ARCH_SHARED = 1'b1
   } fft4_arch_e;
endpackage

// File: rtl/fft4_sm2tc.sv
module fft4_sm2tc #(
   parameter int DW = 8,
   parameter int OW = 10
) (
   input  logic [DW-1:0]        sm_in,
   output logic signed [OW-1:0] tc_out
);
   if (OW < DW) begin : g_bad_width
      $error("fft4_sm2tc: OW must be at least DW");
   end

   logic [OW-1:0] mag_ext;

   always_comb begin
      mag_ext = {{(OW-DW+1){1'b0}}, sm_in[DW-2:0]};
      if (sm_in[DW-1])
         tc_out = -$signed(mag_ext);
      else
         tc_out = $signed(mag_ext);
   end
endmodule

// File: rtl/fft4_tc2sm.sv
module fft4_tc2sm #(
   parameter int DW = 8,
   parameter int IW = 10
) (
   input  logic signed [IW-1:0] tc_in,
   output logic [DW-1:0]        sm_out
);
   localparam logic [IW-1:0] MAX_MAG = {{(IW-DW+1){1'b0}}, {(DW-1){1'b1}}};

   if (IW <= DW) begin : g_bad_width
      $error("fft4_tc2sm: IW must exceed DW");
   end

   logic          neg;
   logic [IW-1:0] mag;

   always_comb begin
      neg = tc_in[IW-1];
      mag = neg ? $unsigned(-tc_in) : $unsigned(tc_in);
      if (mag > MAX_MAG)
         sm_out = {neg, MAX_MAG[DW-2:0]};
      else
         sm_out = {neg, mag[DW-2:0]};
   end
endmodule

// File: rtl/fft4_core.sv
module fft4_core
   import fft4_pkg::*;
#(
   parameter int         IW   = 10,
   parameter fft4_arch_e ARCH = ARCH_SHARED
) (
   input  logic signed [IW-1:0] x_re [LANES],
   input  logic signed [IW-1:0] x_im [LANES],
   output logic signed [IW-1:0] y_re [LANES],
   output logic signed [IW-1:0] y_im [LANES]
);
   if (ARCH == ARCH_SHARED) begin : g_shared
      logic signed [IW-1:0] s0_re, s0_im, s1_re, s1_im;
      logic signed [IW-1:0] t0_re, t0_im, t1_re, t1_im;

      always_comb begin
         s0_re = x_re[0] + x_re[2];
         s0_im = x_im[0] + x_im[2];
         s1_re = x_re[0] - x_re[2];
         s1_im = x_im[0] - x_im[2];
         t0_re = x_re[1] + x_re[3];
         t0_im = x_im[1] + x_im[3];
         t1_re = x_re[1] - x_re[3];
         t1_im = x_im[1] - x_im[3];
         y_re[0] = s0_re + t0_re;
         y_im[0] = s0_im + t0_im;
         y_re[2] = s0_re - t0_re;
         y_im[2] = s0_im - t0_im;
         // -j*t1 : real takes +t1_im, imaginary takes -t1_re
         y_re[1] = s1_re + t1_im;
         y_im[1] = s1_im - t1_re;
         // +j*t1 : real takes -t1_im, imaginary takes +t1_re
         y_re[3] = s1_re - t1_im;
         y_im[3] = s1_im + t1_re;
      end
   end else begin : g_direct
      always_comb begin
         y_re[0] = x_re[0] + x_re[1] + x_re[2] + x_re[3];
         y_im[0] = x_im[0] + x_im[1] + x_im[2] + x_im[3];
         y_re[1] = x_re[0] + x_im[1] - x_re[2] - x_im[3];
         y_im[1] = x_im[0] - x_re[1] - x_im[2] + x_re[3];
         y_re[2] = x_re[0] - x_re[1] + x_re[2] - x_re[3];
         y_im[2] = x_im[0] - x_im[1] + x_im[2] - x_im[3];
         y_re[3] = x_re[0] - x_im[1] - x_re[2] + x_im[3];
         y_im[3] = x_im[0] + x_re[1] - x_im[2] - x_re[3];
      end
   end
endmodule

// File: rtl/fft4_radix4.sv
module fft4_radix4 #(
   parameter int                   DW   = 8,
   parameter fft4_pkg::fft4_arch_e ARCH = fft4_pkg::ARCH_SHARED
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_vld,
   input  logic [fft4_pkg::LANES*DW-1:0]   in_re,
   input  logic [fft4_pkg::LANES*DW-1:0]   in_im,
   output logic                            out_vld,
   output logic [fft4_pkg::LANES*DW-1:0]   out_re,
   output logic [fft4_pkg::LANES*DW-1:0]   out_im
);
   import fft4_pkg::*;

   localparam int          IW       = DW + $clog2(LANES);
   localparam int          BW       = LANES * DW;
   localparam logic [DW-1:0] NEG_ZERO = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] POS_MAX  = {1'b0, {(DW-1){1'b1}}};

   if (DW < 3 || DW > 16) begin : g_bad_dw
      $error("fft4_radix4: DW must lie in 3..16");
   end

   logic signed [IW-1:0] x_re [LANES];
   logic signed [IW-1:0] x_im [LANES];
   logic signed [IW-1:0] y_re [LANES];
   logic signed [IW-1:0] y_im [LANES];
   logic [BW-1:0]        res_re, res_im;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      fft4_sm2tc #(.DW(DW), .OW(IW)) u_in_re (
         .sm_in(in_re[k*DW +: DW]), .tc_out(x_re[k]));
      fft4_sm2tc #(.DW(DW), .OW(IW)) u_in_im (
         .sm_in(in_im[k*DW +: DW]), .tc_out(x_im[k]));
      fft4_tc2sm #(.DW(DW), .IW(IW)) u_out_re (
         .tc_in(y_re[k]), .sm_out(res_re[k*DW +: DW]));
      fft4_tc2sm #(.DW(DW), .IW(IW)) u_out_im (
         .tc_in(y_im[k]), .sm_out(res_im[k*DW +: DW]));

      AST_NO_NEG_ZERO_RE: assert property (@(posedge clk) disable iff (!rst_n)
         out_re[k*DW +: DW] != NEG_ZERO); // R8
      AST_NO_NEG_ZERO_IM: assert property (@(posedge clk) disable iff (!rst_n)
         out_im[k*DW +: DW] != NEG_ZERO); // R8
   end

   fft4_core #(.IW(IW), .ARCH(ARCH)) u_core (
      .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_re  <= '0;
         out_im  <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_re <= res_re;
            out_im <= res_im;
         end
      end
   end

   AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld); // R9
   AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> !out_vld); // R9
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> ($stable(out_re) && $stable(out_im))); // R10
   AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_re == '0 && in_im == '0) |=> (out_re == '0 && out_im == '0)); // R2
   AST_SAT_POS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_re == {LANES{POS_MAX}} && in_im == '0)
      |=> (out_re[DW-1:0] == POS_MAX)); // R7
endmodule

// File: tb/tb_fft4_radix4.sv
module tb_fft4_radix4;
   localparam int DW = 8;
   localparam int BW = 4 * DW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0;
   logic [BW-1:0] in_re = '0, in_im = '0;
   logic out_vld_a, out_vld_b;
   logic [BW-1:0] out_re_a, out_im_a, out_re_b, out_im_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int exp_re [4];
   int exp_im [4];
   string lane_tag [4] = '{"R2", "R3", "R4", "R5"};

   always #2 clk = ~clk;

   fft4_radix4 #(.DW(DW), .ARCH(fft4_pkg::ARCH_SHARED)) dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
      .out_vld(out_vld_a), .out_re(out_re_a), .out_im(out_im_a));

   fft4_radix4 #(.DW(DW), .ARCH(fft4_pkg::ARCH_DIRECT)) dut_direct (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
      .out_vld(out_vld_b), .out_re(out_re_b), .out_im(out_im_b));

   function automatic int sm_val(input logic [7:0] c);
      return c[7] ? -int'(c[6:0]) : int'(c[6:0]);
   endfunction

   function automatic int sm_code(input int v);
      int m = (v < 0) ? -v : v;
      if (m > 127) m = 127;
      if (m == 0) return 0;
      return ((v < 0) ? 128 : 0) + m;
   endfunction

   task automatic model();
      int ar = sm_val(in_re[7:0]),   ai = sm_val(in_im[7:0]);
      int br = sm_val(in_re[15:8]),  bi = sm_val(in_im[15:8]);
      int cr = sm_val(in_re[23:16]), ci = sm_val(in_im[23:16]);
      int dr = sm_val(in_re[31:24]), di = sm_val(in_im[31:24]);
      exp_re[0] = sm_code(ar + br + cr + dr); exp_im[0] = sm_code(ai + bi + ci + di);
      exp_re[1] = sm_code(ar + bi - cr - di); exp_im[1] = sm_code(ai - br - ci + dr);
      exp_re[2] = sm_code(ar - br + cr - dr); exp_im[2] = sm_code(ai - bi + ci - di);
      exp_re[3] = sm_code(ar - bi - cr + di); exp_im[3] = sm_code(ai + br - ci - dr);
   endtask

   task automatic check(input string tag, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
      end
   endtask

   task automatic check_lanes(input string tag);
      for (int k = 0; k < 4; k++) begin
         string t = (tag == "") ? lane_tag[k] : tag;
         check(t, $sformatf("shared re lane %0d", k), int'(out_re_a[k*8 +: 8]), exp_re[k]);
         check(t, $sformatf("shared im lane %0d", k), int'(out_im_a[k*8 +: 8]), exp_im[k]);
         check(t, $sformatf("direct re lane %0d", k), int'(out_re_b[k*8 +: 8]), exp_re[k]);
         check(t, $sformatf("direct im lane %0d", k), int'(out_im_b[k*8 +: 8]), exp_im[k]);
      end
   endtask

   // drive one input set at a falling edge, check one cycle later
   task automatic apply(input logic [BW-1:0] re, input logic [BW-1:0] im, input string tag);
      @(negedge clk);
      in_re = re; in_im = im; in_vld = 1'b1;
      model();
      @(negedge clk);
      in_vld = 1'b0;
      check("R9", "out_vld shared", int'(out_vld_a), 1);
      check("R9", "out_vld direct", int'(out_vld_b), 1);
      check_lanes(tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_F47A));
      repeat (3) @(negedge clk);
      check("R11", "out_vld after reset", int'(out_vld_a | out_vld_b), 0);
      check("R11", "out_re after reset", int'(|{out_re_a, out_re_b}), 0);
      check("R11", "out_im after reset", int'(|{out_im_a, out_im_b}), 0);
      rst_n = 1'b1;

      // R12 / R1: worked real example
      apply({8'h01, 8'h04, 8'h08, 8'h0C}, '0, "R12");
      check("R1", "lane0 re code", int'(out_re_a[7:0]), 8'h19);
      check("R1", "lane1 im code", int'(out_im_a[15:8]), 8'h87);
      check("R1", "lane3 im code", int'(out_im_a[31:24]), 8'h07);

      // R6: x1 = +0.5j alone
      apply('0, {8'h00, 8'h00, 8'h08, 8'h00}, "R6");
      check("R6", "lane1 re +0.5", int'(out_re_a[15:8]), 8'h08);
      check("R6", "lane3 re -0.5", int'(out_re_a[31:24]), 8'h88);

      // R7: saturation both signs
      apply({4{8'h7F}}, {4{8'hFF}}, "R7");
      check("R7", "lane0 re +max", int'(out_re_a[7:0]), 8'h7F);
      check("R7", "lane0 im -max", int'(out_im_a[7:0]), 8'hFF);

      // R8: negative zero input and exact cancellation
      apply({8'h80, 8'h80, 8'h80, 8'h80}, {8'h80, 8'h00, 8'h80, 8'h00}, "R8");
      apply({8'h00, 8'h05, 8'h00, 8'h05}, {8'h03, 8'h00, 8'h03, 8'h00}, "R8");
      check("R8", "lane1 re cancels positive", int'(out_re_a[15:8]), 8'h00);

      // R10: idle cycle with changed inputs holds outputs
      @(negedge clk);
      in_re = {4{8'h33}}; in_im = {4{8'hC4}}; in_vld = 1'b0;
      @(negedge clk);
      check("R9", "out_vld low after idle", int'(out_vld_a | out_vld_b), 0);
      check_lanes("R10");

      // random sets, some separated by idle cycles
      for (int n = 0; n < 300; n++) begin
         logic [BW-1:0] r = $urandom();
         logic [BW-1:0] i = $urandom();
         apply(r, i, "");
         if (($urandom() & 3) == 0) begin
            @(negedge clk);
            in_re = $urandom(); in_im = $urandom();
            @(negedge clk);
            check("R10", "out_vld low while idle", int'(out_vld_a), 0);
            check_lanes("R10");
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule